// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the bus-facing half of a small serial memory. It holds a 2048-byte array and exposes it over a four-wire synchronous serial bus with a separate active-low pause input. The host pulls the select line low, clocks in one command byte and, for memory commands, a 16-bit address. It then streams any number of data bytes in or out. The address steps after every byte and wraps from the top of the array to zero. Written bytes land in the array the moment their eighth bit arrives, so there is never a busy period.

The slave runs on a fast system clock. The serial clock, select and pause inputs pass through a two-stage synchroniser before edge detection, so the serial clock must stay below a quarter of the system clock. Permission to write is decided by a neighbouring protection unit:
- The slave pulses the write-enable set and clear commands out to that unit.
- It hands over status bytes the host writes, and returns the status byte the unit supplies.
- It shows the current array address and stores a data byte only when `mem_wr_ok` is high.

The controller is one state machine with these states:
- `ST_IDLE`: deselected.
- `ST_OPCODE`: collecting the command byte.
- `ST_ADDR`: collecting the 16-bit address.
- `ST_WR_DATA`: storing data.
- `ST_RD_DATA`: streaming data out.
- `ST_STAT_OUT`: returning the status byte.
- `ST_STAT_IN`: taking in a status byte.
- `ST_SKIP`: ignoring the bus until deselect.

Transitions:
- IDLE goes to OPCODE when select falls.
- OPCODE goes to ADDR for codes 03h and 02h, to STAT_OUT for 05h, to STAT_IN for 01h, and to SKIP for 06h, 04h and every other code.
- ADDR goes to RD_DATA or WR_DATA after the sixteenth address bit.
- STAT_OUT and STAT_IN go to SKIP after eight bits.
- Every state returns to IDLE when select is high while pause is high.

Top module: `spi_mem_slave`

## Requirements
- R1: Bus modes 0 and 3 both work. Input bits are taken on rising serial-clock edges and output bits change on falling edges, most significant bit first. The first byte after select falls is the command.
- R2: Command 06h gives a one-cycle `cmd_wen_set` pulse and command 04h gives a one-cycle `cmd_wen_clr` pulse. Neither takes further bytes, and at most one of `cmd_wen_set`, `cmd_wen_clr` and `stat_wr` is high in any cycle.
- R3: Command 05h drives the `stat_rdata` byte on `ser_dout` over the next eight clocks. `ser_dout_en` is released after that byte.
- R4: Command 01h takes one following byte and presents it on `stat_wdata` with a one-cycle `stat_wr` pulse.
- R5: Command 03h takes a 16-bit address whose upper five bits are ignored, then streams array bytes from that address, one per eight clocks. `ser_din` is ignored during the data phase.
- R6: Command 02h takes a 16-bit address (upper five bits ignored). Each later byte is stored once its eighth bit is in, if `mem_wr_ok` is high at that moment; otherwise it is dropped. The address advances after each byte either way.
- R7: The byte address (`cur_addr`) wraps from 7FFh to 000h for both reads and writes.
- R8: Select going high ends the command, and a partially received write byte is discarded. While deselected, `ser_dout_en` is low.
- R9: An unrecognised command causes every later bit to be ignored until select rises: no pulses and no output drive.
- R10: While `ser_pause_n` is low, serial-clock and select edges are ignored and `ser_dout_en` is low. The address and state are frozen, and the transfer resumes at the same bit after release.
- R11: Only one command is accepted per selection: a second command byte inside the same selection has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low select |
| ser_pause_n | input | 1 | Active-low pause |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| ser_dout_en | output | 1 | Output drive enable (low means high impedance) |
| mem_wr_ok | input | 1 | Protection unit permits a store at `cur_addr` |
| cur_addr | output | ADDR_W | Current array byte address |
| cmd_wen_set | output | 1 | Pulse: write-enable set command seen |
| cmd_wen_clr | output | 1 | Pulse: write-enable clear command seen |
| stat_rdata | input | 8 | Status byte returned by command 05h |
| stat_wr | output | 1 | Pulse: a status byte was received |
| stat_wdata | output | 8 | Status byte received by command 01h |

## Verification
The bench builds the block with its default `ADDR_W` of 11. The 7FFh-to-000h wrap therefore sits only a few bytes from a chosen start address, and the five ignored address bits can be set to junk. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchroniser delay on both edges. A pause is inserted mid-byte in both a write and a read, with the clock and select toggling during the pause, so R10 is exercised in both data directions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_EN_WR   = 8'h06;
    localparam logic [7:0] OP_DIS_WR  = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_SKIP
    } fsm_state_t;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/spi_mem_fsm.sv
module spi_mem_fsm
    import spi_mem_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel_n_s,
    input  logic              pause_n_s,
    input  logic              din_s,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_wr_ok,
    input  logic [BYTE_W-1:0] stat_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              dout,
    output logic              dout_en,
    output logic              wen_set,
    output logic              wen_clr,
    output logic              stat_we,
    output logic [BYTE_W-1:0] stat_wdata,
    output fsm_state_t        state_o
);
    fsm_state_t state_q, state_d;

    logic [3:0]        bit_q;
    logic [AW-2:0]     shift_q;
    logic [AW-1:0]     addr_q;
    logic [BYTE_W-1:0] out_q;
    logic              dout_q;
    logic              is_rd_q;

    logic              leaving;
    logic              byte_end;
    logic              fire;
    logic [BYTE_W-1:0] in_byte;
    logic [BYTE_W-1:0] out_src;
    logic              sending;

    assign leaving  = sel_n_s && pause_n_s && (state_q != ST_IDLE);
    assign byte_end = (state_q == ST_ADDR) ? (bit_q == 4'd15) : (bit_q == 4'd7);
    assign in_byte  = {shift_q[BYTE_W-2:0], din_s};
    assign out_src  = (state_q == ST_RD_DATA) ? mem_rdata : stat_rdata;
    assign sending  = (state_q == ST_RD_DATA) || (state_q == ST_STAT_OUT);
    assign fire     = sclk_rise && !leaving && byte_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (leaving) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (!sel_n_s && pause_n_s) state_d = ST_OPCODE;
                ST_OPCODE:
                    if (sclk_rise && byte_end) begin
                        if (in_byte == OP_MEM_RD || in_byte == OP_MEM_WR)
                            state_d = ST_ADDR;
                        else if (in_byte == OP_STAT_RD)
                            state_d = ST_STAT_OUT;
                        else if (in_byte == OP_STAT_WR)
                            state_d = ST_STAT_IN;
                        else
                            state_d = ST_SKIP;
                    end
                ST_ADDR:
                    if (sclk_rise && byte_end)
                        state_d = is_rd_q ? ST_RD_DATA : ST_WR_DATA;
                ST_STAT_OUT, ST_STAT_IN:
                    if (sclk_rise && byte_end) state_d = ST_SKIP;
                ST_WR_DATA, ST_RD_DATA, ST_SKIP:
                    state_d = state_q;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            shift_q <= '0;
            addr_q  <= '0;
            out_q   <= '0;
            dout_q  <= 1'b0;
            is_rd_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || leaving) begin
                bit_q <= '0;
            end else if (sclk_rise && state_q != ST_SKIP) begin
                shift_q <= {shift_q[AW-3:0], din_s};
                bit_q   <= byte_end ? 4'd0 : bit_q + 4'd1;
                if (state_q == ST_OPCODE && byte_end)
                    is_rd_q <= (in_byte == OP_MEM_RD);
                if (state_q == ST_ADDR && byte_end)
                    addr_q <= {shift_q, din_s};
                if ((state_q == ST_WR_DATA || state_q == ST_RD_DATA) && byte_end)
                    addr_q <= addr_q + AW'(1);
            end
            if (sclk_fall && !leaving && sending) begin
                if (bit_q == 4'd0) begin
                    dout_q <= out_src[BYTE_W-1];
                    out_q  <= {out_src[BYTE_W-2:0], 1'b0};
                end else begin
                    dout_q <= out_q[BYTE_W-1];
                    out_q  <= {out_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        dout       = dout_q;
        dout_en    = pause_n_s && !sel_n_s && sending;
        mem_addr   = addr_q;
        mem_wdata  = in_byte;
        stat_wdata = in_byte;
        mem_we     = fire && (state_q == ST_WR_DATA) && mem_wr_ok;
        stat_we    = fire && (state_q == ST_STAT_IN);
        wen_set    = fire && (state_q == ST_OPCODE) && (in_byte == OP_EN_WR);
        wen_clr    = fire && (state_q == ST_OPCODE) && (in_byte == OP_DIS_WR);
        state_o    = state_q;
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_pause_n,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_en,
    input  logic              mem_wr_ok,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cmd_wen_set,
    output logic              cmd_wen_clr,
    input  logic [7:0]        stat_rdata,
    output logic              stat_wr,
    output logic [7:0]        stat_wdata
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  synced;
    logic              pause_s, sel_s, sclk_s, din_s, sclk_d;
    logic              rise, fall;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    fsm_state_t        fsm_state;

    spi_mem_sync #(.W(NSYNC), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_pause_n, ser_sel_n, ser_clk, ser_din}),
        .q       (synced)
    );

    assign {pause_s, sel_s, sclk_s, din_s} = synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise = pause_s &&  sclk_s && !sclk_d;
    assign fall = pause_s && !sclk_s &&  sclk_d;

    spi_mem_fsm #(.AW(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (rise),
        .sclk_fall  (fall),
        .sel_n_s    (sel_s),
        .pause_n_s  (pause_s),
        .din_s      (din_s),
        .mem_rdata  (mem_rdata),
        .mem_wr_ok  (mem_wr_ok),
        .stat_rdata (stat_rdata),
        .mem_we     (mem_we),
        .mem_addr   (cur_addr),
        .mem_wdata  (mem_wdata),
        .dout       (ser_dout),
        .dout_en    (ser_dout_en),
        .wen_set    (cmd_wen_set),
        .wen_clr    (cmd_wen_clr),
        .stat_we    (stat_wr),
        .stat_wdata (stat_wdata),
        .state_o    (fsm_state)
    );

    spi_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (cur_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_s,
    input logic              pause_s,
    input logic              dout_en,
    input fsm_state_t        st,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_we,
    input logic              wen_set,
    input logic              wen_clr,
    input logic              stat_wr
);
    // R8: deselected (and not paused) means output released next cycle
    p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && pause_s) |=> !dout_en);

    // R10: no output drive while paused
    p_pause_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_s |-> !dout_en);

    // R10: state and address frozen across a paused cycle
    p_pause_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_s |=> ($stable(st) && $stable(addr)));

    // R7: every stored byte advances the address by one, modulo the array size
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr == $past(addr) + ADDR_W'(1)));

    // R2: command pulses never overlap
    p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wen_set, wen_clr, stat_wr}));

    // R9: once skipping, only deselect leaves the skip state
    p_skip_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> (st == ST_SKIP || st == ST_IDLE));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s   (sel_s),
    .pause_s (pause_s),
    .dout_en (ser_dout_en),
    .st      (fsm_state),
    .addr    (cur_addr),
    .mem_we  (mem_we),
    .wen_set (cmd_wen_set),
    .wen_clr (cmd_wen_clr),
    .stat_wr (stat_wr)
);

// File: tb/sim_spi_mem_slave.sv
`timescale 1ns/1ps
module sim_spi_mem_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_sel_n = 1'b1, ser_pause_n = 1'b1, ser_din = 1'b0;
    logic        ser_dout, ser_dout_en, mem_wr_ok = 1'b1;
    logic [10:0] cur_addr;
    logic        cmd_wen_set, cmd_wen_clr, stat_wr;
    logic [7:0]  stat_rdata = 8'h00, stat_wdata;

    int tests = 0, fails = 0;
    int n_set = 0, n_clr = 0, n_swr = 0;
    logic [7:0] last_sw = 8'h00;
    int quiet_cnt = 0, quiet_bad = 0, oe_hits = 0;
    bit done = 0;

    logic [7:0] ref_mem [int];
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;

    spi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_pause_n(ser_pause_n), .ser_din(ser_din), .ser_dout(ser_dout),
        .ser_dout_en(ser_dout_en), .mem_wr_ok(mem_wr_ok), .cur_addr(cur_addr),
        .cmd_wen_set(cmd_wen_set), .cmd_wen_clr(cmd_wen_clr),
        .stat_rdata(stat_rdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata)
    );

    // per-clock reference monitor: pulses and output release (R2, R4, R8, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_wen_set) n_set++;
            if (cmd_wen_clr) n_clr++;
            if (stat_wr) begin n_swr++; last_sw = stat_wdata; end
            if (ser_sel_n || !ser_pause_n) quiet_cnt++; else quiet_cnt = 0;
            if (quiet_cnt > 4 && ser_dout_en) quiet_bad++;
            if (!ser_sel_n && ser_dout_en) oe_hits++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic r);
        ser_clk = 1'b0;
        ser_din = b;
        hp();
        r = ser_dout;
        ser_clk = 1'b1;
        hp();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            send_bit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic select(input bit m3);
        @(negedge clk);
        ser_clk = m3;
        hp();
        ser_sel_n = 1'b0;
        hp();
    endtask

    task automatic deselect(input bit m3);
        if (!m3) begin ser_clk = 1'b0; hp(); end
        ser_sel_n = 1'b1;
        hp(); hp();
    endtask

    task automatic pause_mid(input bit toggle_sel, input string req);
        ser_clk = 1'b0;
        hp();
        ser_pause_n = 1'b0;
        hp();
        for (int k = 0; k < 3; k++) begin
            ser_clk = 1'b1; ser_din = ~ser_din; hp();
            ser_clk = 1'b0; hp();
        end
        if (toggle_sel) begin
            ser_sel_n = 1'b1; hp();
            ser_sel_n = 1'b0; hp();
        end
        chk(req, ser_dout_en, 1'b0);
        ser_pause_n = 1'b1;
        hp();
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input bit m3);
        logic [7:0] rx;
        select(m3);
        xfer(8'h02, rx);
        xfer(a[15:8], rx);
        xfer(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xfer(wbuf[k], rx);
            if (mem_wr_ok) ref_mem[(int'(a[10:0]) + k) % 2048] = wbuf[k];
        end
        deselect(m3);
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input bit m3, input string req);
        logic [7:0] rx;
        select(m3);
        xfer(8'h03, rx);
        xfer(a[15:8], rx);
        xfer(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xfer(8'($urandom), rx);
            chk(req, rx, ref_mem[(int'(a[10:0]) + k) % 2048]);
        end
        deselect(m3);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int s0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        chk("R8 reset output released", ser_dout_en, 1'b0);
        chk("R7 reset address", cur_addr, 11'h000);

        // R2 set command, mode 0
        select(0); xfer(8'h06, rx); deselect(0);
        chk("R2 set pulse (R1 mode 0)", n_set, 1);

        // R2 clear command, mode 3
        select(1); xfer(8'h04, rx); deselect(1);
        chk("R2 clear pulse (R1 mode 3)", n_clr, 1);

        // R11 second command inside one selection ignored
        select(0); xfer(8'h06, rx); xfer(8'h04, rx); deselect(0);
        chk("R11 first command taken", n_set, 2);
        chk("R11 second command ignored", n_clr, 1);

        // R3 status read
        stat_rdata = 8'hA5;
        select(0); xfer(8'h05, rx); xfer(8'h00, rx);
        chk("R3 status byte", rx, 8'hA5);
        chk("R3 output released after status byte", ser_dout_en, 1'b0);
        deselect(0);

        // R4 status write
        select(1); xfer(8'h01, rx); xfer(8'h8C, rx); deselect(1);
        chk("R4 status pulse", n_swr, 1);
        chk("R4 status data", last_sw, 8'h8C);

        // R6 / R5 write with junk upper address bits, read back in mode 3
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(16'hF900, 3, 0);
        do_read(16'h0100, 3, 1, "R5 read stream (R1 mode 3, R6 stored)");
        do_read(16'hA101, 1, 0, "R5 upper address bits ignored");

        // R7 wrap on write and read
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
        do_write(16'h07FE, 3, 1);
        chk("R7 address wrapped after write", cur_addr, 11'h001);
        do_read(16'h07FF, 2, 0, "R7 read wrap");

        // R6 permission low drops the byte
        wbuf[0] = 8'h66;
        do_write(16'h0200, 1, 0);
        mem_wr_ok = 1'b0;
        wbuf[0] = 8'h99;
        do_write(16'h0200, 1, 0);
        chk("R6 address advances on dropped byte", cur_addr, 11'h201);
        mem_wr_ok = 1'b1;
        do_read(16'h0200, 1, 0, "R6 refused byte not stored");

        // R8 partial byte discarded
        wbuf[0] = 8'h77;
        do_write(16'h0300, 1, 0);
        select(0); xfer(8'h02, rx); xfer(8'h03, rx); xfer(8'h00, rx);
        for (int k = 0; k < 5; k++) begin logic r; send_bit(1'b0, r); end
        deselect(0);
        do_read(16'h0300, 1, 0, "R8 partial byte discarded");

        // R9 unknown command
        s0 = n_set; c0 = n_clr; oe_hits = 0;
        select(0); xfer(8'hA7, rx); xfer(8'h06, rx); xfer(8'h05, rx); deselect(0);
        chk("R9 no pulses after unknown command", n_set + n_clr, s0 + c0);
        chk("R9 no output drive after unknown command", oe_hits, 0);

        // R10 pause mid-byte during a write
        select(0); xfer(8'h02, rx); xfer(8'h04, rx); xfer(8'h00, rx);
        for (int i = 7; i >= 4; i--) begin logic r; send_bit(8'h3C >> i, r); end
        pause_mid(1, "R10 output off while paused (write)");
        for (int i = 3; i >= 0; i--) begin logic r; send_bit(8'h3C >> i, r); end
        deselect(0);
        ref_mem[32'h400] = 8'h3C;
        do_read(16'h0400, 1, 0, "R10 write resumed across pause");

        // R10 pause mid-byte during a read
        select(0); xfer(8'h03, rx); xfer(8'h04, rx); xfer(8'h00, rx);
        for (int i = 7; i >= 5; i--) begin logic r; send_bit(1'b0, r); rx[i] = r; end
        pause_mid(0, "R10 output off while paused (read)");
        for (int i = 4; i >= 0; i--) begin logic r; send_bit(1'b1, r); rx[i] = r; end
        deselect(0);
        chk("R10 read resumed across pause", rx, 8'h3C);

        chk("R8 R10 output released whenever deselected or paused", quiet_bad, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule